// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block takes one fast source clock and derives three output banks plus one feedback output from it. Each bank runs at half or a quarter of the source rate, picked by its own one-bit select. The feedback output runs at an eighth or a twelfth of the source rate, picked by a separate select. Every output is a registered, 50% duty-cycle clock. All outputs come from a single free-running frame counter, so their rising edges line up on a common source edge.

An active-low enable gates the three banks and leaves the feedback output running. A disabled bank is held low, and a valid flag goes low with it. A bypass control stops the dividers from advancing on every source cycle. Instead they advance once for each rising edge of a chosen reference clock, and a reference-select input picks one of two reference clocks. The selects, the enable and the bypass and reference controls each pass through a two-flop synchronizer on the source clock. A select or enable change takes effect only at the end of a frame, which is why output frequencies change without runt pulses.

Top module: `mbank_clkdiv`

## Requirements
- R1: With its select bit `bank_sel[b]` at 0, bank b has a period of 2 divider steps, and with it at 1 a period of 4. The output is high for exactly half of each period.
- R2: With `fb_sel` at 0, `fb_clk` has a period of 8 divider steps, and with it at 1 a period of 12. It is high for 4 or 6 steps respectively.
- R3: Every rising edge of `fb_clk` while the banks are valid coincides with a rising edge of all three bank outputs.
- R4: Select changes take effect only at the frame boundary. The frame is 24 divider steps, the least common multiple of all divisors, and all outputs are low in its last step. No high pulse on any output is shorter than a legal half period: 1 or 2 steps for a bank, 4 or 6 for feedback.
- R5: With `oe_n` at 1, all bank outputs are held low and `bank_vld` is 0, while `fb_clk` keeps toggling. With `oe_n` at 0, `bank_vld` is 1.
- R6: An enable change also takes effect only at the frame boundary: `fb_clk` rises on the step after `bank_vld` changes.
- R7: With `bypass` at 1, the dividers advance one step per rising edge of the selected reference clock. With it at 0, they advance one step per source cycle.
- R8: With `ref_pick` at 1, the bypass reference is `ref_pri`, and with it at 0 the reference is `ref_alt`.
- R9: A synchronous active-high `rst` drives every output low. On the first source edge after `rst` is released, all enabled outputs and `fb_clk` go high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Fast source clock that all logic runs on |
| rst | input | 1 | Synchronous active-high reset |
| ref_pri | input | 1 | Primary reference clock for bypass mode |
| ref_alt | input | 1 | Alternate (test) reference clock for bypass mode |
| ref_pick | input | 1 | 1 selects `ref_pri`, 0 selects `ref_alt` |
| bypass | input | 1 | 1 steps the dividers on reference edges |
| oe_n | input | 1 | Active-low enable for the bank outputs |
| bank_sel | input | 3 | Per-bank divisor select, 0 for /2 and 1 for /4 |
| fb_sel | input | 1 | Feedback divisor select, 0 for /8 and 1 for /12 |
| bank_clk | output | 3 | Divided bank clocks |
| bank_vld | output | 1 | High while the bank outputs are enabled |
| fb_clk | output | 1 | Divided feedback clock, never gated |

## Verification
The assertions assume that the control inputs are quasi-static. They assume the controls change rarely compared with a frame, and are held steady while `rst` is active so that the values loaded at reset have settled. They also assume that each reference clock is slower than half the source rate, so that every reference edge is seen once after synchronization. The stimulus changes controls only on falling source edges and then holds them for at least 80 source cycles, or several frames in bypass mode. The two reference clocks have periods of 8 and 14 source cycles. The pulse-width and alignment monitors are paused across reset pulses and bypass transitions, where a partial pulse is expected.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Greatest common divisor, used for frame length and edge grids
    function automatic int unsigned gcd_u(int unsigned a, int unsigned b);
        int unsigned x = a;
        int unsigned y = b;
        int unsigned t;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int unsigned lcm_u(int unsigned a, int unsigned b);
        return (a / gcd_u(a, b)) * b;
    endfunction

    // A divided clock is high in the first half of its period
    function automatic logic in_high_half(int unsigned pos, int unsigned div);
        return (pos % div) < (div / 2);
    endfunction

endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cdiv_ref_tick.sv
module cdiv_ref_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pri,
    input  logic ref_alt,
    input  logic pick,
    input  logic bypass,
    output logic tick
);
    logic [1:0] ref_s;
    logic       cur_ref;
    logic       prev_d, prev_q;

    cdiv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ref_sync (
        .clk  (clk),
        .din  ({ref_pri, ref_alt}),
        .dout (ref_s)
    );

    always_comb begin
        cur_ref = pick ? ref_s[1] : ref_s[0];
        prev_d  = rst ? 1'b0 : cur_ref;
        tick    = bypass ? (cur_ref & ~prev_q) : 1'b1;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import clkdiv_pkg::*;
#(
    parameter int          NUM_BANKS   = 3,
    parameter int unsigned BANK_DIV_LO = 2,
    parameter int unsigned BANK_DIV_HI = 4,
    parameter int unsigned FB_DIV_LO   = 8,
    parameter int unsigned FB_DIV_HI   = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [NUM_BANKS-1:0] sel_in,
    input  logic                 fb_sel_in,
    input  logic                 en_in,
    output logic [NUM_BANKS-1:0] bank_clk,
    output logic                 bank_vld,
    output logic                 fb_clk
);
    localparam int unsigned FRAME   = lcm_u(lcm_u(BANK_DIV_LO, BANK_DIV_HI),
                                            lcm_u(FB_DIV_LO, FB_DIV_HI));
    localparam int unsigned FB_GRID = gcd_u(FB_DIV_LO, FB_DIV_HI);
    localparam int          CNT_W   = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [NUM_BANKS-1:0] act_sel;
        logic                 act_fb;
        logic                 act_en;
        logic [NUM_BANKS-1:0] bank_o;
        logic                 fb_o;
    } state_t;

    state_t st_d, st_q;
    logic   wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (rst) begin
            st_d         = '0;
            st_d.act_sel = sel_in;
            st_d.act_fb  = fb_sel_in;
            st_d.act_en  = en_in;
        end else if (tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                st_d.bank_o[b] = st_q.act_en &
                    in_high_half(32'(st_q.cnt),
                                 st_q.act_sel[b] ? BANK_DIV_HI : BANK_DIV_LO);
            end
            st_d.fb_o = in_high_half(32'(st_q.cnt),
                                     st_q.act_fb ? FB_DIV_HI : FB_DIV_LO);
            // every output is low in the last step: switch settings here
            if (wrap) begin
                st_d.act_sel = sel_in;
                st_d.act_fb  = fb_sel_in;
                st_d.act_en  = en_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bank_clk = st_q.bank_o;
    assign bank_vld = st_q.act_en;
    assign fb_clk   = st_q.fb_o;

    // R1: the frame counter never leaves its range
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

    // R2: feedback rises only on its divisor grid
    p_fb_grid_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fb_o) |-> ((32'($past(st_q.cnt)) % FB_GRID) == 0));

    // R3: feedback rise coincides with all enabled bank rises
    p_align_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.fb_o) && st_q.act_en) |-> (&st_q.bank_o));

    // R4: active selects change only after the last frame step
    p_sel_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$stable(st_q.act_sel) || !$stable(st_q.act_fb)))
        |-> ($past(st_q.cnt) == LAST));

    // R5: disabled banks stay low
    p_oe_low_r5: assert property (@(posedge clk) disable iff (rst)
        !st_q.act_en |-> (st_q.bank_o == '0));

    // R6: enable changes only after the last frame step
    p_en_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(st_q.act_en)) |-> ($past(st_q.cnt) == LAST));

    // R7: without a step the counter holds
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.cnt));
endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv #(
    parameter int          NUM_BANKS   = 3,
    parameter int unsigned BANK_DIV_LO = 2,
    parameter int unsigned BANK_DIV_HI = 4,
    parameter int unsigned FB_DIV_LO   = 8,
    parameter int unsigned FB_DIV_HI   = 12,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                 src_clk,
    input  logic                 rst,
    input  logic                 ref_pri,
    input  logic                 ref_alt,
    input  logic                 ref_pick,
    input  logic                 bypass,
    input  logic                 oe_n,
    input  logic [NUM_BANKS-1:0] bank_sel,
    input  logic                 fb_sel,
    output logic [NUM_BANKS-1:0] bank_clk,
    output logic                 bank_vld,
    output logic                 fb_clk
);
    localparam int CTRL_W = NUM_BANKS + 4;

    logic [CTRL_W-1:0]    ctrl_s;
    logic [NUM_BANKS-1:0] sel_s;
    logic                 fb_sel_s, oe_n_s, pick_s, bypass_s;
    logic                 step;

    cdiv_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
        .clk  (src_clk),
        .din  ({bank_sel, fb_sel, oe_n, ref_pick, bypass}),
        .dout (ctrl_s)
    );

    assign {sel_s, fb_sel_s, oe_n_s, pick_s, bypass_s} = ctrl_s;

    cdiv_ref_tick #(.SYNC_STAGES(SYNC_STAGES)) u_ref_tick (
        .clk     (src_clk),
        .rst     (rst),
        .ref_pri (ref_pri),
        .ref_alt (ref_alt),
        .pick    (pick_s),
        .bypass  (bypass_s),
        .tick    (step)
    );

    cdiv_core #(
        .NUM_BANKS   (NUM_BANKS),
        .BANK_DIV_LO (BANK_DIV_LO),
        .BANK_DIV_HI (BANK_DIV_HI),
        .FB_DIV_LO   (FB_DIV_LO),
        .FB_DIV_HI   (FB_DIV_HI)
    ) u_core (
        .clk       (src_clk),
        .rst       (rst),
        .tick      (step),
        .sel_in    (sel_s),
        .fb_sel_in (fb_sel_s),
        .en_in     (~oe_n_s),
        .bank_clk  (bank_clk),
        .bank_vld  (bank_vld),
        .fb_clk    (fb_clk)
    );
endmodule

// File: tb/mbank_clkdiv_tb_top.sv
`timescale 1ns/1ps
module mbank_clkdiv_tb_top;
    localparam int NB = 3;

    logic          src_clk = 1'b0;
    logic          rst, ref_pri, ref_alt, ref_pick, bypass, oe_n, fb_sel;
    logic [NB-1:0] bank_sel;
    logic [NB-1:0] bank_clk;
    logic          bank_vld, fb_clk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    mbank_clkdiv dut_i (
        .src_clk (src_clk), .rst (rst), .ref_pri (ref_pri), .ref_alt (ref_alt),
        .ref_pick (ref_pick), .bypass (bypass), .oe_n (oe_n),
        .bank_sel (bank_sel), .fb_sel (fb_sel),
        .bank_clk (bank_clk), .bank_vld (bank_vld), .fb_clk (fb_clk)
    );

    always #5 src_clk = ~src_clk;

    initial begin
        ref_pri = 1'b0;
        #3;
        forever #40 ref_pri = ~ref_pri;   // 8 source cycles
    end
    initial begin
        ref_alt = 1'b0;
        #7;
        forever #70 ref_alt = ~ref_alt;   // 14 source cycles
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bank_div(input bit s);
        return s ? 4 : 2;
    endfunction
    function automatic int fb_div(input bit s);
        return s ? 12 : 8;
    endfunction

    // ---------------- output monitor (samples 2 ns after each edge)
    logic [3:0] prev_v = '0;
    logic [3:0] cur_v;
    int  run_len[4], since_rise[4], last_period[4], last_high[4], rise_cnt[4];
    bit  seg_ok[4];
    bit  mon_on = 0;
    bit  prev_vld = 0;
    bit  vld_pend = 0;

    initial begin
        for (int k = 0; k < 4; k++) begin
            run_len[k] = 0; since_rise[k] = 0; last_period[k] = 0;
            last_high[k] = 0; rise_cnt[k] = 0; seg_ok[k] = 0;
        end
    end

    always @(posedge src_clk) begin
        #2;
        cur_v = {fb_clk, bank_clk};
        if (vld_pend) begin
            chk(cur_v[3] && !prev_v[3], "R6 fb rise after enable change", int'(cur_v[3]), 1);
            vld_pend = 0;
        end
        if (mon_on && (bank_vld != prev_vld)) vld_pend = 1;
        prev_vld = bank_vld;
        if (mon_on && cur_v[3] && !prev_v[3] && bank_vld) begin
            chk(cur_v[2:0] == 3'b111 && prev_v[2:0] == 3'b000,
                "R3 bank rise aligned with fb rise", int'(cur_v[2:0]), 7);
        end
        for (int k = 0; k < 4; k++) begin
            since_rise[k]++;
            if (cur_v[k] != prev_v[k]) begin
                if (prev_v[k]) begin
                    if (mon_on && seg_ok[k]) begin
                        if (k < 3)
                            chk(run_len[k] == 1 || run_len[k] == 2, "R4 bank high pulse width", run_len[k], 2);
                        else
                            chk(run_len[k] == 4 || run_len[k] == 6, "R4 fb high pulse width", run_len[k], 6);
                    end
                    last_high[k] = run_len[k];
                end
                if (cur_v[k]) begin
                    last_period[k] = since_rise[k];
                    since_rise[k] = 0;
                    rise_cnt[k]++;
                end
                seg_ok[k] = mon_on;
                run_len[k] = 1;
            end else begin
                run_len[k]++;
            end
        end
        prev_v = cur_v;
    end

    task automatic mon_set(input bit on);
        mon_on = on;
        vld_pend = 0;
        for (int k = 0; k < 4; k++) seg_ok[k] = 0;
    endtask

    // period and high-time checks for all outputs, scaled by step length
    task automatic check_periods(input int step, input string tag_b, input string tag_f);
        for (int b = 0; b < NB; b++) begin
            chk(last_period[b] == bank_div(bank_sel[b]) * step, tag_b,
                last_period[b], bank_div(bank_sel[b]) * step);
            chk(last_high[b] == bank_div(bank_sel[b]) * step / 2, tag_b,
                last_high[b], bank_div(bank_sel[b]) * step / 2);
        end
        chk(last_period[3] == fb_div(fb_sel) * step, tag_f, last_period[3], fb_div(fb_sel) * step);
        chk(last_high[3] == fb_div(fb_sel) * step / 2, tag_f, last_high[3], fb_div(fb_sel) * step / 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge src_clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int r0, fb_r0;
        void'($urandom(32'd7531));
        rst = 1'b1; oe_n = 1'b0; bank_sel = '0; fb_sel = 1'b0;
        bypass = 1'b0; ref_pick = 1'b1;
        repeat (6) @(negedge src_clk);

        // R9 reset state, R5 enabled flag
        chk(bank_clk == 3'b000, "R9 banks low in reset", int'(bank_clk), 0);
        chk(fb_clk == 1'b0, "R9 fb low in reset", int'(fb_clk), 0);
        chk(bank_vld == 1'b1, "R5 valid when oe_n low", int'(bank_vld), 1);
        rst = 1'b0;
        @(negedge src_clk);
        chk(bank_clk == 3'b111, "R9 banks high on first edge", int'(bank_clk), 7);
        chk(fb_clk == 1'b1, "R9 fb high on first edge", int'(fb_clk), 1);
        mon_set(1);

        // R1/R2 directed: all slow, then all fast
        repeat (80) @(negedge src_clk);
        check_periods(1, "R1 bank /2 directed", "R2 fb /8 directed");
        bank_sel = 3'b111; fb_sel = 1'b1;
        repeat (80) @(negedge src_clk);
        check_periods(1, "R1 bank /4 directed", "R2 fb /12 directed");

        // R1/R2/R4 random select changes
        for (int it = 0; it < 16; it++) begin
            bank_sel = NB'($urandom);
            fb_sel   = 1'($urandom);
            repeat (80) @(negedge src_clk);
            check_periods(1, "R1 bank random select", "R2 fb random select");
        end

        // R5 disable: banks low, fb keeps running
        oe_n = 1'b1;
        repeat (40) @(negedge src_clk);
        chk(bank_vld == 1'b0, "R5 valid low when disabled", int'(bank_vld), 1'b0);
        r0 = 0;
        fb_r0 = rise_cnt[3];
        for (int c = 0; c < 48; c++) begin
            @(negedge src_clk);
            if (bank_clk != 3'b000) r0++;
        end
        chk(r0 == 0, "R5 banks held low while disabled", r0, 0);
        chk(rise_cnt[3] - fb_r0 == 48 / fb_div(fb_sel), "R5 fb toggles while disabled",
            rise_cnt[3] - fb_r0, 48 / fb_div(fb_sel));
        oe_n = 1'b0;
        repeat (80) @(negedge src_clk);
        chk(bank_vld == 1'b1, "R5 valid after re-enable", int'(bank_vld), 1);
        check_periods(1, "R5 bank periods after re-enable", "R5 fb period after re-enable");

        // R9 mid-run reset
        mon_set(0);
        rst = 1'b1;
        @(negedge src_clk);
        chk({fb_clk, bank_clk} == 4'b0000, "R9 outputs low after reset edge", int'({fb_clk, bank_clk}), 0);
        @(negedge src_clk);
        rst = 1'b0;
        @(negedge src_clk);
        chk({fb_clk, bank_clk} == 4'b1111, "R9 outputs high after release", int'({fb_clk, bank_clk}), 15);
        mon_set(1);
        repeat (60) @(negedge src_clk);
        check_periods(1, "R9 bank periods after reset", "R9 fb period after reset");

        // R7/R8 bypass with primary reference (8 source cycles per step)
        mon_set(0);
        bank_sel = 3'b010; fb_sel = 1'b0;
        repeat (80) @(negedge src_clk);
        bypass = 1'b1; ref_pick = 1'b1;
        repeat (400) @(negedge src_clk);
        check_periods(8, "R7 bank periods in bypass (primary)", "R8 fb period in bypass (primary)");

        // R8 alternate reference (14 source cycles per step)
        ref_pick = 1'b0;
        repeat (500) @(negedge src_clk);
        check_periods(14, "R8 bank periods in bypass (alternate)", "R8 fb period in bypass (alternate)");

        // R5 in bypass: enable still gates banks
        oe_n = 1'b1;
        repeat (450) @(negedge src_clk);
        chk(bank_vld == 1'b0, "R5 valid low in bypass", int'(bank_vld), 0);
        chk(bank_clk == 3'b000, "R5 banks low in bypass", int'(bank_clk), 0);

        // R7 leave bypass: back to one step per source cycle
        oe_n = 1'b0; bypass = 1'b0;
        repeat (400) @(negedge src_clk);
        check_periods(1, "R7 bank periods after bypass", "R7 fb period after bypass");

        finish_run();
    end
endmodule